// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Monitor

This block watches the command pins of a four-bank DDR SDRAM interface and samples them on every rising clock edge. It turns the pin pattern into a command code, follows each bank through idle, row-active and precharging, and remembers the row that is open in each bank. When a command does not fit the current state of its bank, the block reports a violation pulse with a reason code. A flagged command never changes the tracked state. The block is meant to sit beside a memory controller as a protocol watchdog, or in a test environment as a bus monitor.

Every output is registered. The results for a command sampled at clock edge k appear just after edge k and stay valid until edge k+1. The precharge time and the burst duration are parameters, counted in clock cycles.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With `cs_n` high the cycle decodes as NOP (code 0). With `cs_n` low, `{ras_n,cas_n,we_n}` decode as follows: 111 NOP(0), 011 ACTIVE(1), 101 READ(2), 100 WRITE(3), 110 BURST STOP(4), 010 PRECHARGE, 001 REFRESH, 000 MODE LOAD(9). A NOP is never flagged.
- R2: An ACTIVE to an idle bank makes that bank row-active (`bank_active_o[bank]` = 1) and reports the row from `addr` on `row_o`.
- R3: For a READ or WRITE, `col_o` = `addr[8:0]` and `ap_o` = `addr[10]`. `row_o` shows the row open in the addressed bank. `ap_o` is 0 for every other command.
- R4: A READ or WRITE to a bank that is not row-active, or whose auto-precharge burst is still running, is flagged with code 1 and leaves the state unchanged.
- R5: An ACTIVE to a bank that is row-active, or that is precharging and not yet ready, is flagged with code 2.
- R6: A PRECHARGE with `addr[10]` = 0 reports code 5 and closes only bank `ba`. With `addr[10]` = 1 it reports code 6, closes every bank and ignores `ba`.
- R7: A PRECHARGE to an idle or precharging bank is not flagged and changes nothing.
- R8: A closed bank accepts ACTIVE again TRP_CYC cycles after the precharge. An ACTIVE issued one cycle earlier is flagged with code 2.
- R9: A READ or WRITE with `addr[10]` = 1 closes its bank BURST_CYC cycles after the command. The precharge time of R8 counts from that point.
- R10: BURST STOP is legal only while a read burst without auto-precharge is running, and it ends that burst. Otherwise, including after a write, after an auto-precharge read, or with no burst running, it is flagged with code 3.
- R11: The REFRESH encoding reports auto refresh (code 7) with `cke` high and self-refresh entry (code 8) with `cke` low. Any other selected command with `cke` low is flagged with code 4 and has no effect.
- R12: A MODE LOAD with `ba` = 00 or 10 pulses `mr_wr_o`, with `mr_ext_o` = `ba[1]` and the op-code on `row_o`. With `ba[0]` = 1 it is flagged with code 5 and `mr_wr_o` stays low.
- R13: While `rst_n` is low at a clock edge, all banks become idle, any burst is dropped, and `viol_o`, `mr_wr_o` and `cmd_o` are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock; all pins sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 13 | Row, column or op-code bus; bit 10 is the precharge qualifier |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | 2 | Bank of the decoded command |
| row_o | output | 13 | Activated row, open row for READ/WRITE, or op-code |
| col_o | output | 9 | Start column |
| ap_o | output | 1 | Auto-precharge requested by READ/WRITE |
| mr_wr_o | output | 1 | Accepted mode-register write strobe |
| mr_ext_o | output | 1 | Mode-register target: 0 base, 1 extended |
| viol_o | output | 1 | Violation pulse for the decoded command |
| viol_code_o | output | 3 | Violation reason (0 none) |
| bank_active_o | output | 4 | Row-active flag per bank |

## Verification
The embedded properties assume that the pins settle well before each rising edge and never carry unknown values once reset is released. They also assume that reset is held for at least one edge, so that the per-bank timers start from a known count. The bench changes the pins only on falling edges, holds `rst_n` low over several edges before each run, and drives only the defined encodings. Some of those encodings are deliberately illegal, so that the violation codes and the untouched state can be observed through `viol_code_o` and `bank_active_o`.

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor #(
  parameter int ROW_W     = 13,
  parameter int COL_W     = 9,
  parameter int BANK_W    = 2,
  parameter int AP_BIT    = 10,
  parameter int TRP_CYC   = 3,
  parameter int BURST_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BANK_W-1:0] ba,
  input  logic [ROW_W-1:0]  addr,
  output logic [3:0]        cmd_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o,
  output logic              ap_o,
  output logic              mr_wr_o,
  output logic              mr_ext_o,
  output logic              viol_o,
  output logic [2:0]        viol_code_o,
  output logic [(1<<BANK_W)-1:0] bank_active_o
);
  localparam int NB = 1 << BANK_W;
  localparam int TW = $clog2(TRP_CYC + 1);
  localparam int BW = $clog2(BURST_CYC + 1);

  localparam logic [3:0] C_NOP = 4'd0, C_ACT = 4'd1, C_RD = 4'd2, C_WR = 4'd3, C_BST = 4'd4,
                         C_PRE = 4'd5, C_PREA = 4'd6, C_AREF = 4'd7, C_SREF = 4'd8, C_LMR = 4'd9;
  localparam logic [1:0] S_IDLE = 2'd0, S_OPEN = 2'd1, S_PRE = 2'd2;

  logic [1:0]       st   [NB];
  logic [ROW_W-1:0] rowq [NB];
  logic [TW-1:0]    tcnt [NB];

  logic              b_live, b_rd, b_ap;
  logic [BANK_W-1:0] b_bank;
  logic [BW-1:0]     b_cnt;

  logic [3:0] dcmd;
  logic [2:0] code;

  always_comb begin
    dcmd = C_NOP;
    if (!cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b111: dcmd = C_NOP;
        3'b011: dcmd = C_ACT;
        3'b101: dcmd = C_RD;
        3'b100: dcmd = C_WR;
        3'b110: dcmd = C_BST;
        3'b010: dcmd = addr[AP_BIT] ? C_PREA : C_PRE;
        3'b001: dcmd = cke ? C_AREF : C_SREF;
        default: dcmd = C_LMR;
      endcase
    end
  end

  wire bank_ready = (st[ba] == S_IDLE) || (st[ba] == S_PRE && tcnt[ba] == TW'(1));
  wire bank_open  = (st[ba] == S_OPEN) && !(b_live && b_ap && b_bank == ba);
  wire bst_ok     = b_live && b_rd && !b_ap;

  always_comb begin
    code = 3'd0;
    if (!cke && dcmd != C_NOP && dcmd != C_SREF) code = 3'd4;
    else begin
      unique case (dcmd)
        C_ACT:       if (!bank_ready) code = 3'd2;
        C_RD, C_WR:  if (!bank_open)  code = 3'd1;
        C_BST:       if (!bst_ok)     code = 3'd3;
        C_LMR:       if (ba[0])       code = 3'd5;
        default:     code = 3'd0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) begin
        st[i]   <= S_IDLE;
        rowq[i] <= '0;
        tcnt[i] <= '0;
      end
      b_live <= 1'b0; b_rd <= 1'b0; b_ap <= 1'b0; b_bank <= '0; b_cnt <= '0;
      cmd_o <= C_NOP; bank_o <= '0; row_o <= '0; col_o <= '0;
      ap_o <= 1'b0; mr_wr_o <= 1'b0; mr_ext_o <= 1'b0;
      viol_o <= 1'b0; viol_code_o <= 3'd0;
    end else begin
      for (int i = 0; i < NB; i++)
        if (st[i] == S_PRE) begin
          tcnt[i] <= tcnt[i] - TW'(1);
          if (tcnt[i] == TW'(1)) st[i] <= S_IDLE;
        end

      if (b_live) begin
        b_cnt <= b_cnt - BW'(1);
        if (b_cnt == BW'(1)) begin
          b_live <= 1'b0;
          if (b_ap) begin
            st[b_bank]   <= S_PRE;
            tcnt[b_bank] <= TW'(TRP_CYC);
          end
        end
      end

      if (code == 3'd0) begin
        unique case (dcmd)
          C_ACT: begin
            st[ba]   <= S_OPEN;
            rowq[ba] <= addr;
          end
          C_RD, C_WR: begin
            if (b_live && b_ap) begin
              st[b_bank]   <= S_PRE;
              tcnt[b_bank] <= TW'(TRP_CYC);
            end
            b_live <= 1'b1;
            b_rd   <= (dcmd == C_RD);
            b_ap   <= addr[AP_BIT];
            b_bank <= ba;
            b_cnt  <= BW'(BURST_CYC);
          end
          C_BST: b_live <= 1'b0;
          C_PRE: begin
            if (st[ba] == S_OPEN) begin
              st[ba]   <= S_PRE;
              tcnt[ba] <= TW'(TRP_CYC);
            end
            if (b_bank == ba) b_live <= 1'b0;
          end
          C_PREA: begin
            for (int i = 0; i < NB; i++)
              if (st[i] == S_OPEN) begin
                st[i]   <= S_PRE;
                tcnt[i] <= TW'(TRP_CYC);
              end
            b_live <= 1'b0;
          end
          default: ;
        endcase
      end

      cmd_o       <= dcmd;
      bank_o      <= ba;
      row_o       <= (dcmd == C_RD || dcmd == C_WR) ? rowq[ba] : addr;
      col_o       <= addr[COL_W-1:0];
      ap_o        <= (dcmd == C_RD || dcmd == C_WR) && addr[AP_BIT];
      mr_wr_o     <= (dcmd == C_LMR) && (code == 3'd0);
      mr_ext_o    <= (dcmd == C_LMR) && ba[1];
      viol_o      <= (code != 3'd0);
      viol_code_o <= code;
    end
  end

  always_comb
    for (int i = 0; i < NB; i++) bank_active_o[i] = (st[i] == S_OPEN);

  assert_nop_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == C_NOP) |-> !viol_o);

  assert_act_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == C_ACT && !viol_o) |-> bank_active_o[bank_o]);

  assert_ap_only_rw_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ap_o |-> (cmd_o == C_RD || cmd_o == C_WR));

  assert_rw_on_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_o == C_RD || cmd_o == C_WR) && !viol_o) |-> (b_live && b_bank == bank_o));

  assert_preall_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == C_PREA && !viol_o) |-> (bank_active_o == '0));

  assert_mr_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mr_wr_o |-> (cmd_o == C_LMR && !viol_o && !bank_o[0]));
endmodule

// File: tb/sdram_cmd_monitor_test.sv
module sdram_cmd_monitor_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [12:0] addr = '0;
  logic [3:0]  cmd_o;
  logic [1:0]  bank_o;
  logic [12:0] row_o;
  logic [8:0]  col_o;
  logic ap_o, mr_wr_o, mr_ext_o, viol_o;
  logic [2:0]  viol_code_o;
  logic [3:0]  bank_active_o;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  sdram_cmd_monitor uut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .cmd_o(cmd_o), .bank_o(bank_o), .row_o(row_o),
    .col_o(col_o), .ap_o(ap_o), .mr_wr_o(mr_wr_o), .mr_ext_o(mr_ext_o), .viol_o(viol_o),
    .viol_code_o(viol_code_o), .bank_active_o(bank_active_o));

  // {req, exp cmd, exp code, exp active mask, cke, cs_n, ras/cas/we, ba, addr}
  localparam int NV = 23;
  localparam logic [34:0] VEC [NV] = '{
    {4'd1,  4'd0, 3'd0, 4'b0000, 1'b1, 1'b1, 3'b000, 2'd0, 13'h0000}, // R1 deselect
    {4'd1,  4'd0, 3'd0, 4'b0000, 1'b1, 1'b0, 3'b111, 2'd0, 13'h0000}, // R1 NOP
    {4'd4,  4'd2, 3'd1, 4'b0000, 1'b1, 1'b0, 3'b101, 2'd0, 13'h0000}, // R4 read idle bank
    {4'd2,  4'd1, 3'd0, 4'b0010, 1'b1, 1'b0, 3'b011, 2'd1, 13'h1ABC}, // R2 activate
    {4'd5,  4'd1, 3'd2, 4'b0010, 1'b1, 1'b0, 3'b011, 2'd1, 13'h0003}, // R5 re-activate
    {4'd3,  4'd3, 3'd0, 4'b0010, 1'b1, 1'b0, 3'b100, 2'd1, 13'h0055}, // R3 write
    {4'd10, 4'd4, 3'd3, 4'b0010, 1'b1, 1'b0, 3'b110, 2'd0, 13'h0000}, // R10 stop on write
    {4'd1,  4'd0, 3'd0, 4'b0010, 1'b1, 1'b0, 3'b111, 2'd0, 13'h0000},
    {4'd2,  4'd1, 3'd0, 4'b0110, 1'b1, 1'b0, 3'b011, 2'd2, 13'h0005},
    {4'd3,  4'd2, 3'd0, 4'b0110, 1'b1, 1'b0, 3'b101, 2'd2, 13'h0010},
    {4'd10, 4'd4, 3'd0, 4'b0110, 1'b1, 1'b0, 3'b110, 2'd0, 13'h0000}, // R10 legal stop
    {4'd10, 4'd4, 3'd3, 4'b0110, 1'b1, 1'b0, 3'b110, 2'd0, 13'h0000}, // R10 no burst
    {4'd6,  4'd5, 3'd0, 4'b0100, 1'b1, 1'b0, 3'b010, 2'd1, 13'h0000}, // R6 single
    {4'd7,  4'd5, 3'd0, 4'b0100, 1'b1, 1'b0, 3'b010, 2'd1, 13'h0000}, // R7 on precharging
    {4'd8,  4'd1, 3'd2, 4'b0100, 1'b1, 1'b0, 3'b011, 2'd1, 13'h0007}, // R8 too early
    {4'd8,  4'd1, 3'd0, 4'b0110, 1'b1, 1'b0, 3'b011, 2'd1, 13'h0007}, // R8 ready
    {4'd7,  4'd5, 3'd0, 4'b0110, 1'b1, 1'b0, 3'b010, 2'd3, 13'h0000}, // R7 idle bank
    {4'd6,  4'd6, 3'd0, 4'b0000, 1'b1, 1'b0, 3'b010, 2'd3, 13'h0400}, // R6 all
    {4'd12, 4'd9, 3'd0, 4'b0000, 1'b1, 1'b0, 3'b000, 2'd0, 13'h0123}, // R12
    {4'd12, 4'd9, 3'd5, 4'b0000, 1'b1, 1'b0, 3'b000, 2'd1, 13'h0123}, // R12 bad target
    {4'd11, 4'd8, 3'd0, 4'b0000, 1'b0, 1'b0, 3'b001, 2'd0, 13'h0000}, // R11 self refresh
    {4'd11, 4'd1, 3'd4, 4'b0000, 1'b0, 1'b0, 3'b011, 2'd0, 13'h0001}, // R11 cke low
    {4'd11, 4'd7, 3'd0, 4'b0000, 1'b1, 1'b0, 3'b001, 2'd0, 13'h0000}  // R11 auto refresh
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic k, input logic s, input logic [2:0] rcw,
                       input logic [1:0] b, input logic [12:0] a);
    @(negedge clk);
    cke = k; cs_n = s; {ras_n, cas_n, we_n} = rcw; ba = b; addr = a;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    drive(1'b1, 1'b1, 3'b111, 2'd0, 13'h0);
    drive(1'b1, 1'b1, 3'b111, 2'd0, 13'h0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    #800000;
    $display("FAIL watchdog expired");
    total++; bad++;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    chk("R13 cmd after reset", cmd_o, 0);
    chk("R13 viol after reset", viol_o, 0);
    chk("R13 banks after reset", bank_active_o, 0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][19], VEC[i][18], VEC[i][17:15], VEC[i][14:13], VEC[i][12:0]);
      chk($sformatf("R%0d vec%0d cmd", VEC[i][34:31], i), cmd_o, VEC[i][30:27]);
      chk($sformatf("R%0d vec%0d code", VEC[i][34:31], i), viol_code_o, VEC[i][26:24]);
      chk($sformatf("R%0d vec%0d banks", VEC[i][34:31], i), bank_active_o, VEC[i][23:20]);
      if (i == 18) begin
        chk("R12 strobe", mr_wr_o, 1);
        chk("R12 base target", mr_ext_o, 0);
        chk("R12 op-code", row_o, 13'h0123);
      end
      if (i == 19) chk("R12 no strobe on bad target", mr_wr_o, 0);
    end

    do_reset();
    drive(1'b1, 1'b0, 3'b000, 2'd2, 13'h0042);
    chk("R12 extended strobe", mr_wr_o, 1);
    chk("R12 extended target", mr_ext_o, 1);

    drive(1'b1, 1'b0, 3'b011, 2'd0, 13'h00AA);
    chk("R2 row", row_o, 13'h00AA);
    drive(1'b1, 1'b0, 3'b101, 2'd0, 13'h0403);
    chk("R3 col", col_o, 9'h003);
    chk("R3 ap", ap_o, 1);
    chk("R3 open row", row_o, 13'h00AA);
    chk("R4 read accepted", viol_o, 0);
    drive(1'b1, 1'b0, 3'b110, 2'd0, 13'h0);
    chk("R10 stop after ap read", viol_code_o, 3);
    chk("R9 still open mid burst", bank_active_o, 4'b0001);
    drive(1'b1, 1'b0, 3'b111, 2'd0, 13'h0);
    chk("R9 closed at burst end", bank_active_o, 4'b0000);
    drive(1'b1, 1'b0, 3'b111, 2'd0, 13'h0);
    drive(1'b1, 1'b0, 3'b011, 2'd0, 13'h0011);
    chk("R8 early act after ap", viol_code_o, 2);
    drive(1'b1, 1'b0, 3'b011, 2'd0, 13'h0011);
    chk("R8 act after ap precharge", viol_code_o, 0);
    chk("R9 reopened", bank_active_o, 4'b0001);

    @(negedge clk); rst_n = 1'b0;
    drive(1'b1, 1'b0, 3'b011, 2'd3, 13'h0001);
    chk("R13 reset clears banks", bank_active_o, 0);
    chk("R13 reset clears viol", viol_o, 0);
    chk("R13 reset clears cmd", cmd_o, 0);
    @(negedge clk); rst_n = 1'b1;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule